// File: doc/BRIEF.md
# Selectable-Order Burst Address Sequencer

This block produces the word address for a four-beat burst. When a load is accepted, it takes in a full external start address. Each accepted advance then steps the two low address bits to the next beat. The upper bits keep the value captured at load for the whole burst. After four advances the low bits return to their starting value.

A mode input chooses how the low bits move:

- **Interleaved (mode high):** the low bits are the loaded bits XORed with a beat count.
- **Linear (mode low):** the low bits are the loaded bits plus the beat count, kept to two bits.

A clock enable freezes the whole block. The address output is driven from registered state through one small mapping stage. A load accepted at a clock edge is therefore visible on the output right after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous active-low reset is low at a rising edge, the output address becomes all zeros after that edge, whatever the other inputs are.
- R2: A rising edge with `ce`=1 and `load`=1 captures `start_addr`, and the output equals `start_addr` after that edge.
- R3: With `order_ilv`=1, successive advances after a load give the low two bits as start^01, start^10 and start^11.
- R4: With `order_ilv`=0, successive advances after a load give the low two bits as (start+1), (start+2) and (start+3), each taken modulo 4.
- R5: The fourth advance after a load returns the low two bits to their loaded value, in both orders.
- R6: Advances never change the output bits above the two low bits, even when a linear step wraps from 3 to 0.
- R7: With `ce`=0, the output holds its value, and `load`, `advance` and `start_addr` have no effect.
- R8: `load` takes priority over `advance`. A load in the middle of a burst restarts the beat count, so the next advance yields the first beat of the new burst.
- R9: With `ce`=1, `load`=0 and `advance`=0, the output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable, active high; when low, all state holds |
| load | input | 1 | Capture `start_addr` and restart the beat count |
| advance | input | 1 | Step to the next beat (ignored when `load` is high) |
| order_ilv | input | 1 | 1 = interleaved (XOR) order, 0 = linear (add) order |
| start_addr | input | ADDR_W | Burst start address |
| addr_o | output | ADDR_W | Current word address |

## Verification
The bench builds the block with ADDR_W=10 and BEAT_W=2. The ten-bit width allows start addresses whose upper bits are all ones, all zeros or mixed. This makes any carry out of the low field, or any disturbance of the captured upper bits, show up at once. With BEAT_W=2, every start value of the low bits can be reached. In particular, the linear case starting at 3, which wraps on its first step, and the interleaved case are both walked through a full four-beat wrap.

// File: rtl/burst_seq_pkg.sv
// Package: shared definitions for the burst address sequencer.
// Assumes the beat field width never exceeds the address width.
package burst_seq_pkg;

    // Encoding of the order-select input.
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
// burst_beat_ctr: counts the beats of the current burst.
// Clears on reset or on an accepted load; wraps naturally at 2**BEAT_W.
// Assumes load has priority over advance and that ce gates everything
// except reset.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              load,
    input  logic              advance,
    output logic [BEAT_W-1:0] beat_o
);

    logic [BEAT_W-1:0] beat_q;

    // Beat register: clear, restart, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (ce) begin
            if (load) begin
                beat_q <= '0;
            end else if (advance) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign beat_o = beat_q;

    // With clock enable low, the beat count must not move.
    assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(beat_o));

    // A load restarts the burst at beat zero.
    assert_load_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && load) |=> (beat_o == '0));

    // Each advance steps by one and wraps after the last beat.
    assert_beat_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !load && advance) |=> (beat_o == BEAT_W'($past(beat_o) + 1'b1)));

endmodule

// File: rtl/burst_order_map.sv
// burst_order_map: turns the loaded low bits and a beat count into the
// low bits of the current address, in interleaved or linear order.
// Purely combinational; assumes mode is held steady across a burst.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_ilv,
    output logic [BEAT_W-1:0] lo_o
);

    burst_order_e order;

    // Select XOR or wrapping add by the order input.
    always_comb begin
        order = burst_order_e'(order_ilv);
        if (order == ORDER_INTERLEAVED) begin
            lo_o = base_lo ^ beat;
        end else begin
            lo_o = base_lo + beat;
        end
    end

    // Beat zero must always give the loaded low bits back, in either order.
    always_comb begin
        if (beat == '0) begin
            assert_beat0_base_R5: assert (lo_o == base_lo);
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
// burst_addr_seq: top of the burst address sequencer.
// Captures the full start address on load. It then presents the upper
// bits unchanged and the low BEAT_W bits stepped in the selected order.
// Assumes ADDR_W > BEAT_W and a synchronous, active-low reset.
module burst_addr_seq #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              load,
    input  logic              advance,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] lo_cur;

    // Start-address register: cleared on reset, refilled on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (ce && load) begin
            base_q <= start_addr;
        end
    end

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .load    (load),
        .advance (advance),
        .beat_o  (beat)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .base_lo   (base_q[BEAT_W-1:0]),
        .beat      (beat),
        .order_ilv (order_ilv),
        .lo_o      (lo_cur)
    );

    assign addr_o = {base_q[ADDR_W-1:BEAT_W], lo_cur};

    // A load makes the whole start address visible after the edge.
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && load) |=> (addr_o == $past(start_addr)));

    // Upper bits never move unless a load is accepted.
    assert_upper_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && load) |=> $stable(addr_o[ADDR_W-1:ADDR_W-HI_W]));

    // An idle enabled cycle under a fixed order leaves the address alone.
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !load && !advance && $stable(order_ilv)) |=> $stable(addr_o));

endmodule

// File: tb/tb_burst_addr_seq.sv
// tb_burst_addr_seq: table-driven check of the burst address sequencer,
// followed by directed reset and upper-bit carry tests.
module tb_burst_addr_seq;

    localparam int AW = 10;
    localparam int BW = 2;
    localparam int NV = 17;
    localparam int VW = 4 + 4 + AW + AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0;
    logic          load = 1'b0;
    logic          advance = 1'b0;
    logic          order_ilv = 1'b1;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] addr_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // 125 MHz clock
    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ce),
        .load       (load),
        .advance    (advance),
        .order_ilv  (order_ilv),
        .start_addr (start_addr),
        .addr_o     (addr_o)
    );

    // Row fields: {req, ce, load, advance, order_ilv, start_addr, expected}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2, 1'b1, 1'b1, 1'b0, 1'b1, 10'h2C5, 10'h2C5}, // R2 load, interleaved
        {4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2C4}, // R3 01^01
        {4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2C7}, // R3 01^10
        {4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2C6}, // R3 01^11
        {4'd5, 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 10'h2C5}, // R5 wrap
        {4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 10'h13B, 10'h13B}, // R2 load, linear
        {4'd6, 1'b1, 1'b0, 1'b1, 1'b0, 10'h000, 10'h138}, // R6 3+1 -> 0, no carry
        {4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 10'h000, 10'h139}, // R4 3+2
        {4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 10'h3FF, 10'h139}, // R7 ce low
        {4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 10'h3FF, 10'h139}, // R9 idle
        {4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 10'h000, 10'h13A}, // R4 3+3
        {4'd5, 1'b1, 1'b0, 1'b1, 1'b0, 10'h000, 10'h13B}, // R5 wrap linear
        {4'd4, 1'b1, 1'b0, 1'b1, 1'b0, 10'h000, 10'h138}, // R4 second lap
        {4'd8, 1'b1, 1'b1, 1'b1, 1'b1, 10'h0A2, 10'h0A2}, // R8 load beats advance
        {4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 10'h0A3}, // R3 10^01
        {4'd8, 1'b1, 1'b1, 1'b0, 1'b1, 10'h0A2, 10'h0A2}, // R8 reload mid-burst
        {4'd8, 1'b1, 1'b0, 1'b1, 1'b1, 10'h000, 10'h0A3}  // R8 beat restarted
    };

    // Compare one output value against its expectation.
    task automatic check(input logic [AW-1:0] exp, input int req);
        n_cmp++;
        if (addr_o !== exp) begin
            n_bad++;
            $display("FAIL R%0d: addr_o=%h expected=%h", req, addr_o, exp);
        end
    endtask

    // Drive one cycle at the falling edge, sample just after the rising edge.
    task automatic step(input logic c, input logic l, input logic a,
                        input logic m, input logic [AW-1:0] s);
        @(negedge clk);
        ce = c; load = l; advance = a; order_ilv = m; start_addr = s;
        @(posedge clk);
        #2;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b1, 1'b0, 1'b1, 10'h155);
        check(10'h000, 1);
        step(1'b1, 1'b1, 1'b0, 1'b1, 10'h155);
        check(10'h000, 1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][VW-5], VEC[i][VW-6], VEC[i][VW-7], VEC[i][VW-8],
                 VEC[i][2*AW-1:AW]);
            check(VEC[i][AW-1:0], int'(VEC[i][VW-1:VW-4]));
        end

        // R6: all-ones upper bits with a linear wrap from 3
        step(1'b1, 1'b1, 1'b0, 1'b0, 10'h3FF);
        check(10'h3FF, 6);
        step(1'b1, 1'b0, 1'b1, 1'b0, 10'h000);
        check(10'h3FC, 6);

        // R1: reset overrides a disabled clock enable
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b1, 1'b0, 10'h000);
        check(10'h000, 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: linear order from start 0 after reset
        step(1'b1, 1'b1, 1'b0, 1'b0, 10'h200);
        check(10'h200, 2);
        step(1'b1, 1'b0, 1'b1, 1'b0, 10'h000);
        check(10'h201, 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule